// File: doc/BRIEF.md
# MSI Event Queue Controller

This block takes message-signalled interrupt writes from the PCIe side and turns each one into a 64-byte event record that is written into a ring buffer in system memory. Each request carries a target address, 16 bits of data, a requester ID and a flag that marks it as a 32-bit or 64-bit message. The low bits of the data select an MSI number. That number indexes a mapping table, and the table entry names one of the event queues. Each queue is a ring of 128 records placed at a fixed stride above a programmable base address.

For every queue the hardware keeps a tail pointer and software keeps a head pointer. An interrupt line stays asserted while the queue is enabled and holds unread records. Each MSI carries a pending flag that stops further records from that MSI until software clears the flag. When a queue fills up, the record is dropped, the overflow flag is set and the queue enters an error state. Software reads and writes the table, the queue control, the state, and the head and tail pointers through a simple register port.

Top module: `msiq_ctrl`

## Requirements
- R1: After reset every queue reads state 1 (idle), its head and tail read 0, its overflow flag is clear and its interrupt is low. Every mapping entry reads 0 and no memory write is requested.
- R2: An MSI is delivered when all of these hold: its address hits the window, its number is below NUM_MSI, its mapping entry is valid with the pending flag clear, and the target queue exists, is enabled and is not in error. Delivery issues one memory write at base + queue×8192 + tail×64, sets the entry's pending flag (bit 62) and advances the tail by one modulo 128.
- R3: Record layout, with word 0 in data bits [63:0] and word 1 in bits [127:64]. Word 0 holds {0, fmt[6:0], length=1 [9:0], addr[15:2], requester ID, MSI data}. fmt is 7'h58 for a 32-bit MSI and 7'h78 for a 64-bit MSI. Word 1 holds {addr[63:16], 16'h0}. Bits [511:128] are zero.
- R4: A message that fails any condition in R2 produces no memory write and leaves the tail and the pending flag unchanged.
- R5: A write with bit 62 set to the clear register of an MSI clears that MSI's pending flag. If the write falls in the same cycle as a delivery that sets the same flag, the flag ends up set.
- R6: If advancing the tail would make it equal to the head, no record is written. The overflow flag (tail register bit 57) is set and the queue enters state 4 (error).
- R7: In the set register, bit 44 enables the queue and bit 57 sets overflow together with the error state. In the clear register, bit 44 disables the queue, bit 57 clears the overflow flag and bit 47 leaves the error state. The state reads 4 while in error, otherwise 2 if enabled, otherwise 1.
- R8: A queue's interrupt output is registered and is high exactly when the queue is enabled and head ≠ tail. It follows a register or delivery update in the next cycle.
- R9: The register address is {region[15:12], index[11:0]}. Region 0 holds index 0 = queue base (bits 63:13), index 1 = 32-bit window (bits 31:16) and index 2 = 64-bit window (bits 63:16). The remaining regions are: 1 = mapping entry (bit 63 valid, bit 62 pending read-only, bits 5:0 queue), 2 = MSI clear, 3 = queue set, 4 = queue clear, 5 = queue state, 6 = tail (bits 6:0, bit 57 overflow), 7 = head. Read data appears on reg_rdata one cycle after the read strobe.
- R10: A memory request holds mem_valid, mem_addr and mem_data steady until mem_ready. No new MSI is accepted while a request is outstanding.
- R11: A 32-bit MSI hits the window when addr[31:16] matches the 32-bit window. A 64-bit MSI hits the window when addr[63:16] matches the 64-bit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msi_valid | input | 1 | MSI request present |
| msi_ready | output | 1 | MSI request accepted this cycle |
| msi_addr | input | 64 | MSI target address |
| msi_data | input | 16 | MSI data, low bits give the MSI number |
| msi_rid | input | 16 | Requester ID |
| msi_is64 | input | 1 | 1 for a 64-bit MSI |
| mem_valid | output | 1 | Record write request |
| mem_ready | input | 1 | Memory accepts the record |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 512 | Record contents |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 16 | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| eq_irq | output | NUM_EQ | Per-queue interrupt |

## Verification
Two things can happen to one MSI's pending flag in the same cycle: a delivery sets it while a software clear-register write tries to drop it. The bench provokes this by issuing the clear write in the cycle right after the MSI handshake, which is the cycle in which the delivery decision is registered. It then reads the mapping entry back and expects the pending bit to be set, while the scoreboard still expects the record. A second overlap, where a record is held back and a new MSI is offered, is checked by stalling mem_ready and confirming that msi_ready stays low and the request stays stable.

// File: rtl/msiq_pkg.sv
package msiq_pkg;
  localparam int REC_W  = 512;
  localparam int PTR_W  = 7;
  localparam logic [6:0] FT_MSI32 = 7'h58;
  localparam logic [6:0] FT_MSI64 = 7'h78;
  localparam int B_VALID = 63;
  localparam int B_PEND  = 62;
  localparam int B_OFLOW = 57;
  localparam int B_E2I   = 47;
  localparam int B_EN    = 44;
  localparam logic [3:0] RG_GLOBAL = 4'h0;
  localparam logic [3:0] RG_MAP    = 4'h1;
  localparam logic [3:0] RG_MCLR   = 4'h2;
  localparam logic [3:0] RG_QSET   = 4'h3;
  localparam logic [3:0] RG_QCLR   = 4'h4;
  localparam logic [3:0] RG_QSTATE = 4'h5;
  localparam logic [3:0] RG_QTAIL  = 4'h6;
  localparam logic [3:0] RG_QHEAD  = 4'h7;

  typedef enum logic [2:0] {ST_IDLE = 3'b001, ST_ACTIVE = 3'b010, ST_ERROR = 3'b100} qstate_e;

  function automatic logic [REC_W-1:0] make_record(input logic [63:0] addr, input logic [15:0] data,
                                                   input logic [15:0] rid, input logic is64);
    logic [63:0] w0, w1;
    w0 = {1'b0, (is64 ? FT_MSI64 : FT_MSI32), 10'd1, addr[15:2], rid, data};
    w1 = {addr[63:16], 16'h0000};
    return {{(REC_W-128){1'b0}}, w1, w0};
  endfunction
endpackage

// File: rtl/msiq_map.sv
module msiq_map
  import msiq_pkg::*;
#(
  parameter int NUM_MSI = 32,
  localparam int MI_W = $clog2(NUM_MSI)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sw_we,
  input  logic                    sw_clr,
  input  logic [MI_W-1:0]         sw_idx,
  input  logic                    sw_valid,
  input  logic [5:0]              sw_eq,
  input  logic                    hw_set,
  input  logic [MI_W-1:0]         hw_idx,
  output logic [NUM_MSI-1:0]      valid_o,
  output logic [NUM_MSI-1:0]      pend_o,
  output logic [NUM_MSI-1:0][5:0] eq_o
);
  for (genvar i = 0; i < NUM_MSI; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_o[i] <= 1'b0;
        pend_o[i]  <= 1'b0;
        eq_o[i]    <= '0;
      end else begin
        if (sw_we && sw_idx == MI_W'(i)) begin
          valid_o[i] <= sw_valid;
          eq_o[i]    <= sw_eq;
        end
        if (hw_set && hw_idx == MI_W'(i))
          pend_o[i] <= 1'b1;
        else if (sw_clr && sw_idx == MI_W'(i))
          pend_o[i] <= 1'b0;
      end
    end
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> pend_o[$past(hw_idx)]);
endmodule

// File: rtl/msiq_queue.sv
module msiq_queue
  import msiq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             set_of,
  input  logic             clr_en,
  input  logic             clr_of,
  input  logic             clr_e2i,
  input  logic             head_we,
  input  logic             tail_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             hw_push,
  input  logic             hw_oflow,
  output logic             en_o,
  output logic             err_o,
  output logic             of_o,
  output logic [2:0]       state_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             irq_o
);
  logic en_n, err_n, of_n;
  logic [PTR_W-1:0] hd_n, tl_n;

  always_comb begin
    en_n  = en_o;
    err_n = err_o;
    of_n  = of_o;
    hd_n  = head_o;
    tl_n  = tail_o;
    if (set_en) en_n = 1'b1;
    if (set_of) begin of_n = 1'b1; err_n = 1'b1; end
    if (clr_en) en_n = 1'b0;
    if (clr_of) of_n = 1'b0;
    if (clr_e2i) err_n = 1'b0;
    if (hw_oflow) begin of_n = 1'b1; err_n = 1'b1; end
    if (head_we) hd_n = ptr_wdata;
    if (hw_push) tl_n = tail_o + PTR_W'(1);
    else if (tail_we) tl_n = ptr_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o    <= 1'b0;
      err_o   <= 1'b0;
      of_o    <= 1'b0;
      head_o  <= '0;
      tail_o  <= '0;
      state_o <= ST_IDLE;
      irq_o   <= 1'b0;
    end else begin
      en_o    <= en_n;
      err_o   <= err_n;
      of_o    <= of_n;
      head_o  <= hd_n;
      tail_o  <= tl_n;
      state_o <= err_n ? ST_ERROR : (en_n ? ST_ACTIVE : ST_IDLE);
      irq_o   <= en_n && (hd_n != tl_n);
    end
  end

  // R6
  oflow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hw_oflow && !tail_we && !clr_e2i |=> $stable(tail_o) && of_o && state_o == ST_ERROR);
  // R8
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !irq_o);
endmodule

// File: rtl/msiq_ctrl.sv
module msiq_ctrl
  import msiq_pkg::*;
#(
  parameter int NUM_MSI = 32,
  parameter int NUM_EQ  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              msi_valid,
  output logic              msi_ready,
  input  logic [63:0]       msi_addr,
  input  logic [15:0]       msi_data,
  input  logic [15:0]       msi_rid,
  input  logic              msi_is64,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [63:0]       mem_addr,
  output logic [REC_W-1:0]  mem_data,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [15:0]       reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic [NUM_EQ-1:0] eq_irq
);
  localparam int MI_W = $clog2(NUM_MSI);
  localparam int EQ_W = $clog2(NUM_EQ);

  // software side decode
  logic [3:0]  region;
  logic [11:0] ridx;
  logic        wr, sidx_ok, sq_ok;
  logic [MI_W-1:0] si;
  logic [EQ_W-1:0] sq;
  assign region  = reg_addr[15:12];
  assign ridx    = reg_addr[11:0];
  assign wr      = reg_en && reg_we;
  assign si      = ridx[MI_W-1:0];
  assign sq      = ridx[EQ_W-1:0];
  assign sidx_ok = {1'b0, ridx} < 13'(NUM_MSI);
  assign sq_ok   = {1'b0, ridx} < 13'(NUM_EQ);

  logic [50:0] base_q;
  logic [15:0] win32_q;
  logic [47:0] win64_q;

  // captured request
  logic        r_pend, r_is64;
  logic [63:0] r_addr;
  logic [15:0] r_data, r_rid;

  // mapping table
  logic [NUM_MSI-1:0]      map_valid, map_pend;
  logic [NUM_MSI-1:0][5:0] map_eq;
  logic [MI_W-1:0]         m_idx;
  logic                    push, ovf, go, full, idx_ok, q_ok, win_hit;
  logic [5:0]              tq;
  logic [EQ_W-1:0]         qi;

  // queue state
  logic [NUM_EQ-1:0] q_en, q_err, q_of;
  logic [2:0]        q_state [NUM_EQ];
  logic [PTR_W-1:0]  q_head  [NUM_EQ];
  logic [PTR_W-1:0]  q_tail  [NUM_EQ];

  assign m_idx   = r_data[MI_W-1:0];
  assign idx_ok  = r_data < 16'(NUM_MSI);
  assign tq      = map_eq[m_idx];
  assign qi      = tq[EQ_W-1:0];
  assign q_ok    = {1'b0, tq} < 7'(NUM_EQ);
  assign win_hit = r_is64 ? (r_addr[63:16] == win64_q) : (r_addr[31:16] == win32_q);
  assign go      = r_pend && idx_ok && win_hit && map_valid[m_idx] && !map_pend[m_idx]
                   && q_ok && q_en[qi] && !q_err[qi];
  assign full    = (q_tail[qi] + PTR_W'(1)) == q_head[qi];
  assign push    = go && !full;
  assign ovf     = go && full;
  assign msi_ready = !r_pend && !mem_valid;

  msiq_map #(.NUM_MSI(NUM_MSI)) u_map (
    .clk(clk), .rst(rst),
    .sw_we(wr && region == RG_MAP && sidx_ok),
    .sw_clr(wr && region == RG_MCLR && sidx_ok && reg_wdata[B_PEND]),
    .sw_idx(si), .sw_valid(reg_wdata[B_VALID]), .sw_eq(reg_wdata[5:0]),
    .hw_set(push), .hw_idx(m_idx),
    .valid_o(map_valid), .pend_o(map_pend), .eq_o(map_eq));

  for (genvar i = 0; i < NUM_EQ; i++) begin : g_q
    logic hit;
    assign hit = wr && ridx == 12'(i);
    msiq_queue u_q (
      .clk(clk), .rst(rst),
      .set_en (hit && region == RG_QSET && reg_wdata[B_EN]),
      .set_of (hit && region == RG_QSET && reg_wdata[B_OFLOW]),
      .clr_en (hit && region == RG_QCLR && reg_wdata[B_EN]),
      .clr_of (hit && region == RG_QCLR && reg_wdata[B_OFLOW]),
      .clr_e2i(hit && region == RG_QCLR && reg_wdata[B_E2I]),
      .head_we(hit && region == RG_QHEAD),
      .tail_we(hit && region == RG_QTAIL),
      .ptr_wdata(reg_wdata[PTR_W-1:0]),
      .hw_push (push && qi == EQ_W'(i)),
      .hw_oflow(ovf && qi == EQ_W'(i)),
      .en_o(q_en[i]), .err_o(q_err[i]), .of_o(q_of[i]), .state_o(q_state[i]),
      .head_o(q_head[i]), .tail_o(q_tail[i]), .irq_o(eq_irq[i]));
  end

  logic [63:0] rd_n;
  always_comb begin
    rd_n = '0;
    case (region)
      RG_GLOBAL:
        case (ridx)
          12'd0:   rd_n = {base_q, 13'b0};
          12'd1:   rd_n = {32'b0, win32_q, 16'b0};
          12'd2:   rd_n = {win64_q, 16'b0};
          default: rd_n = '0;
        endcase
      RG_MAP:    if (sidx_ok) rd_n = {map_valid[si], map_pend[si], 56'b0, map_eq[si]};
      RG_QSTATE: if (sq_ok) rd_n = {61'b0, q_state[sq]};
      RG_QTAIL:  if (sq_ok) rd_n = {6'b0, q_of[sq], 50'b0, q_tail[sq]};
      RG_QHEAD:  if (sq_ok) rd_n = {57'b0, q_head[sq]};
      default:   rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_pend <= 1'b0; r_is64 <= 1'b0; r_addr <= '0; r_data <= '0; r_rid <= '0;
      mem_valid <= 1'b0; mem_addr <= '0; mem_data <= '0;
      base_q <= '0; win32_q <= '0; win64_q <= '0; reg_rdata <= '0;
    end else begin
      r_pend <= msi_valid && msi_ready;
      if (msi_valid && msi_ready) begin
        r_addr <= msi_addr; r_data <= msi_data; r_rid <= msi_rid; r_is64 <= msi_is64;
      end
      if (push) begin
        mem_valid <= 1'b1;
        mem_addr  <= {base_q, 13'b0} + 64'({tq, 13'b0}) + 64'({q_tail[qi], 6'b0});
        mem_data  <= make_record(r_addr, r_data, r_rid, r_is64);
      end else if (mem_ready) begin
        mem_valid <= 1'b0;
      end
      if (wr && region == RG_GLOBAL) begin
        if (ridx == 12'd0) base_q  <= reg_wdata[63:13];
        if (ridx == 12'd1) win32_q <= reg_wdata[31:16];
        if (ridx == 12'd2) win64_q <= reg_wdata[63:16];
      end
      if (reg_en && !reg_we) reg_rdata <= rd_n;
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
  // R10
  no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> !msi_ready);
  // R4
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    r_pend && !go |=> !mem_valid);
endmodule

// File: tb/msiq_ctrl_tb.sv
module msiq_ctrl_tb;
  localparam int CLK_NS  = 10;
  localparam int NUM_MSI = 32;
  localparam int NUM_EQ  = 8;
  localparam logic [63:0] EN  = 64'h1 << 44;
  localparam logic [63:0] OF  = 64'h1 << 57;
  localparam logic [63:0] E2I = 64'h1 << 47;
  localparam logic [63:0] PND = 64'h1 << 62;
  localparam logic [63:0] VLD = 64'h1 << 63;

  logic clk = 0, rst = 1;
  logic msi_valid = 0, msi_ready, msi_is64 = 0;
  logic [63:0] msi_addr = '0;
  logic [15:0] msi_data = '0, msi_rid = '0;
  logic mem_valid, mem_ready = 0;
  logic [63:0] mem_addr;
  logic [511:0] mem_data;
  logic reg_en = 0, reg_we = 0;
  logic [15:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic [NUM_EQ-1:0] eq_irq;

  msiq_ctrl #(.NUM_MSI(NUM_MSI), .NUM_EQ(NUM_EQ)) u_dut (
    .clk(clk), .rst(rst), .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
    .msi_data(msi_data), .msi_rid(msi_rid), .msi_is64(msi_is64), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .reg_en(reg_en),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eq_irq(eq_irq));

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit stall = 0, finished = 0;
  typedef struct packed { logic [63:0] a; logic [511:0] d; } exp_t;
  exp_t sb[$];

  bit sh_valid[NUM_MSI], sh_pend[NUM_MSI];
  int sh_eq[NUM_MSI];
  bit sh_en[NUM_EQ], sh_err[NUM_EQ], sh_of[NUM_EQ];
  int sh_head[NUM_EQ], sh_tail[NUM_EQ];
  logic [63:0] sh_base = '0, sh_w32 = '0, sh_w64 = '0;

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_en = 0;
  endtask

  task automatic map_set(input int m, input int q);
    wr({4'h1, 12'(m)}, VLD | 64'(q)); sh_valid[m] = 1; sh_eq[m] = q;
  endtask
  task automatic mclr(input int m);
    wr({4'h2, 12'(m)}, PND); sh_pend[m] = 0;
  endtask
  task automatic qset(input int q, input logic [63:0] b);
    wr({4'h3, 12'(q)}, b);
    if (b[44]) sh_en[q] = 1;
    if (b[57]) begin sh_of[q] = 1; sh_err[q] = 1; end
  endtask
  task automatic qclr(input int q, input logic [63:0] b);
    wr({4'h4, 12'(q)}, b);
    if (b[44]) sh_en[q] = 0;
    if (b[57]) sh_of[q] = 0;
    if (b[47]) sh_err[q] = 0;
  endtask
  task automatic whead(input int q, input int v);
    wr({4'h7, 12'(q)}, 64'(v)); sh_head[q] = v;
  endtask

  task automatic chk_q(input string tag, input int q);
    logic [63:0] v;
    rd({4'h5, 12'(q)}, v);
    chk(tag, v, sh_err[q] ? 4 : (sh_en[q] ? 2 : 1));
    rd({4'h6, 12'(q)}, v);
    chk(tag, v, {6'b0, sh_of[q], 50'b0, 7'(sh_tail[q])});
    chk({tag, " R8 irq"}, eq_irq[q], sh_en[q] && (sh_head[q] != sh_tail[q]));
  endtask

  task automatic chk_map(input string tag, input int m);
    logic [63:0] v;
    rd({4'h1, 12'(m)}, v);
    chk(tag, v, {sh_valid[m], sh_pend[m], 56'b0, 6'(sh_eq[m])});
  endtask

  task automatic send(input logic [63:0] a, input logic [15:0] d, input logic [15:0] rid,
                      input bit is64, input bit clr_same);
    bit hit, go;
    int q, m;
    @(negedge clk); msi_valid = 1; msi_addr = a; msi_data = d; msi_rid = rid; msi_is64 = is64;
    while (!msi_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk); msi_valid = 0;
    if (clr_same) begin reg_en = 1; reg_we = 1; reg_addr = {4'h2, 12'(d)}; reg_wdata = PND; end
    m = int'(d);
    hit = is64 ? (a[63:16] == sh_w64[63:16]) : (a[31:16] == sh_w32[31:16]);
    go = 0;
    if (m < NUM_MSI && hit) begin
      q = sh_eq[m];
      if (sh_valid[m] && !sh_pend[m] && q < NUM_EQ) go = sh_en[q] && !sh_err[q];
    end
    if (go) begin
      if (((sh_tail[q] + 1) % 128) == sh_head[q]) begin
        sh_of[q] = 1; sh_err[q] = 1;
      end else begin
        sb.push_back('{a: sh_base + 64'(q) * 64'd8192 + 64'(sh_tail[q]) * 64'd64,
                       d: {384'b0, a[63:16], 16'h0, 1'b0, (is64 ? 7'h78 : 7'h58), 10'd1,
                           a[15:2], rid, d}});
        sh_pend[m] = 1;
        sh_tail[q] = (sh_tail[q] + 1) % 128;
      end
    end
    @(negedge clk); reg_en = 0; reg_we = 0;
    if (clr_same && !go && m < NUM_MSI) sh_pend[m] = 0;
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops the scoreboard as records leave the design
  initial begin
    forever begin
      @(negedge clk);
      if (mem_valid && !mem_ready && !stall) begin
        if (sb.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R4 unexpected write actual=%h expected=none", mem_addr);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk("R2 address", mem_addr, e.a);
          chk("R3 record", mem_data, e.d);
        end
        mem_ready = 1;
      end else begin
        mem_ready = 0;
      end
    end
  end

  initial begin
    #(CLK_NS * 50000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] v, held;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk_q("R1 q0", 0);
    chk_q("R1 q7", 7);
    chk_map("R1 map", 5);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 irq", eq_irq, 0);

    // R9 global registers
    wr(16'h0000, 64'h0000_0040_0000_0000); sh_base = 64'h0000_0040_0000_0000;
    wr(16'h0001, 64'h0000_0000_FEE0_0000); sh_w32 = 64'hFEE0_0000;
    wr(16'h0002, 64'h0000_00AB_CDEF_0000); sh_w64 = 64'h0000_00AB_CDEF_0000;
    rd(16'h0000, v); chk("R9 base", v, sh_base);
    rd(16'h0001, v); chk("R9 win32", v, sh_w32);
    rd(16'h0002, v); chk("R9 win64", v, sh_w64);

    // R7 enable, R2 delivery
    map_set(5, 3); mclr(5); qset(3, EN);
    chk_q("R7 enable", 3);
    send(64'h0000_0000_FEE0_0010, 16'd5, 16'h1234, 0, 0);
    chk_q("R2 first", 3);
    chk_map("R2 pending set", 5);
    // R4 pending blocks
    send(64'h0000_0000_FEE0_0010, 16'd5, 16'h1234, 0, 0);
    chk_q("R4 pending drop", 3);
    // R5 clear, R11 64-bit hit
    mclr(5);
    chk_map("R5 cleared", 5);
    send(64'h0000_00AB_CDEF_1234, 16'd5, 16'hBEEF, 1, 0);
    chk_q("R11 64-bit hit", 3);
    mclr(5);
    send(64'h0000_0000_FEF0_0000, 16'd5, 16'h0001, 0, 0);
    chk_q("R11 32-bit miss", 3);
    send(64'h0000_01AB_CDEF_0000, 16'd5, 16'h0001, 1, 0);
    chk_q("R11 64-bit miss", 3);
    // R8 head catch-up
    whead(3, sh_tail[3]);
    chk_q("R8 head equals tail", 3);
    // R4 invalid, out of range, disabled queue
    send(64'hFEE0_0000, 16'd7, 16'h0, 0, 0);
    send(64'hFEE0_0000, 16'd40, 16'h0, 0, 0);
    map_set(9, 1); mclr(9);
    send(64'hFEE0_0000, 16'd9, 16'h0, 0, 0);
    chk_q("R4 disabled queue", 1);
    chk_q("R4 unmapped", 3);

    // R6 overflow
    map_set(6, 2); mclr(6); qset(2, EN); whead(2, 2);
    send(64'hFEE0_0000, 16'd6, 16'h0006, 0, 0);
    mclr(6);
    send(64'hFEE0_0000, 16'd6, 16'h0006, 0, 0);
    chk_q("R6 overflow", 2);
    chk_map("R6 pending untouched", 6);
    send(64'hFEE0_0000, 16'd6, 16'h0006, 0, 0);
    chk_q("R6 error drops", 2);
    qclr(2, E2I);
    chk_q("R7 leave error", 2);
    qclr(2, OF);
    chk_q("R7 clear overflow", 2);
    qset(2, OF);
    chk_q("R7 forced overflow", 2);
    qclr(2, OF | E2I | EN);
    chk_q("R7 disable", 2);

    // R10 stalled memory port
    stall = 1;
    mclr(5);
    send(64'hFEE0_0000, 16'd5, 16'h5555, 0, 0);
    chk("R10 valid held", mem_valid, 1);
    chk("R10 no accept", msi_ready, 0);
    held = mem_addr;
    chk("R10 address", mem_addr, sb[0].a);
    repeat (3) @(negedge clk);
    chk("R10 stable", mem_addr, held);
    stall = 0;
    repeat (3) @(negedge clk);

    // R5 same-cycle set and clear
    mclr(5);
    send(64'hFEE0_0000, 16'd5, 16'h7777, 0, 1);
    chk_map("R5 set wins", 5);
    chk_q("R5 queue", 3);

    repeat (5) @(negedge clk);
    chk("R2 scoreboard drained", 32'(sb.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule